// File: doc/BRIEF.md
# Overwriting Prefetch Request Queue

This block sits between the address-prediction logic of a data prefetcher and the bus that links the first-level data cache to the second level. Predicted block addresses are pushed into a small ring of slots. A request leaves the ring only in a cycle when the bus carries no demand traffic, so demand references always go first. The oldest waiting request is the one that leaves. When the ring is full, a new prediction replaces the oldest waiting one and is not refused. Under a long backlog, old predictions are the least likely to still be useful, so they are the ones to give up.

The block also watches the demand addresses on the bus. A waiting request for a block that a demand access has just fetched is cancelled. Pushes that repeat a block already waiting are dropped, so two prediction sources can feed the same port. Two counters record lost requests: one for requests displaced by a full ring, the other for requests cancelled by demand snoops.

Top module: `prefetch_issue_queue`

## Requirements
- R1: After reset the ring is empty, `issue_valid` is 0 and both removal counters read 0.
- R2: `issue_valid` is 0 in every cycle where `bus_busy` is 1. Requests pushed meanwhile are all kept for later.
- R3: In a cycle with `bus_busy` low and a live request waiting, `issue_valid` is 1 and `issue_addr` carries the oldest live request's block address with the low `BLK_BITS` bits zero. A request pushed in cycle t can issue from cycle t+1 on.
- R4: A push that is accepted when the ring already holds `DEPTH` requests and nothing issues that cycle evicts the oldest live request. It increments `cnt_overwrite` by one, and the other requests keep their order.
- R5: On a full ring, a push in the same cycle as an issue takes the slot that the issue frees and leaves `cnt_overwrite` unchanged.
- R6: Two addresses belong to the same block when they agree above the low `BLK_BITS` bits. A push for a block already live in the ring is discarded, with no count.
- R7: A snoop (`snoop_valid` high) whose block matches a live request cancels that request in the same cycle. The request is never issued, and `cnt_stale` increments by the number cancelled.
- R8: Cancelled requests cost no issue cycle. When the oldest request is cancelled, the next live one issues in that same cycle. A cancelled request in the middle of the ring is passed over without a gap between issues.
- R9: A push whose block matches the snoop of the same cycle is discarded, with no count.
- R10: The ring holds `DEPTH` requests (16 by default) without loss. A cancelled request keeps its slot until it becomes the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| push_valid | input | 1 | A predicted prefetch address is offered |
| push_addr | input | ADDR_W | Offered prefetch address |
| bus_busy | input | 1 | Demand traffic occupies the L1-L2 bus this cycle |
| snoop_valid | input | 1 | A demand access is seen on the bus |
| snoop_addr | input | ADDR_W | Address of the snooped demand access |
| issue_valid | output | 1 | A prefetch request goes out on the bus this cycle |
| issue_addr | output | ADDR_W | Block-aligned address of the issued request |
| cnt_overwrite | output | CNT_W | Running count of requests evicted by a full ring |
| cnt_stale | output | CNT_W | Running count of requests cancelled by demand snoops |

## Verification
The bench builds the queue with `DEPTH`=4, `ADDR_W`=16, `BLK_BITS`=4 and `CNT_W`=8. The shallow ring fills in four pushes, so eviction, the full-ring push-plus-issue case and hole skipping all occur within a few cycles. The 4-bit block offset lets the bench offer an address that differs from a waiting one only inside its block, which exercises the duplicate filter. A ring model in the bench keeps cancelled requests in their slots, so the capacity it predicts follows the hole rule in R10.

// File: rtl/piq_pkg.sv
package piq_pkg;
  // What happens to an offered request in one cycle
  typedef enum logic [1:0] {
    PUSH_NONE   = 2'd0,
    PUSH_DROP   = 2'd1,
    PUSH_APPEND = 2'd2,
    PUSH_EVICT  = 2'd3
  } push_kind_e;
endpackage

// File: rtl/piq_match.sv
module piq_match #(
  parameter int DEPTH = 16,
  parameter int BLK_W = 27
) (
  input  logic [DEPTH-1:0][BLK_W-1:0] blk,
  input  logic [DEPTH-1:0]            vld,
  input  logic                        en,
  input  logic [BLK_W-1:0]            key,
  output logic [DEPTH-1:0]            hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = en && vld[i] && (blk[i] == key);
  end
endmodule

// File: rtl/piq_pick.sv
module piq_pick #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] live,
  input  logic [PTR_W-1:0] head,
  input  logic [OCC_W-1:0] occ,
  output logic [OCC_W-1:0] off
);
  // Distance from head to the first live slot within the occupied span
  always_comb begin
    off = occ;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (k < int'(occ) && live[(int'(head) + k) % DEPTH]) off = OCC_W'(k);
    end
  end
endmodule

// File: rtl/piq_tally.sv
module piq_tally #(
  parameter int CNT_W = 16,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovw_inc,
  input  logic [INC_W-1:0] stale_inc,
  output logic [CNT_W-1:0] cnt_ovw,
  output logic [CNT_W-1:0] cnt_stale
);
  logic             ovw_en, stale_en;
  logic [CNT_W-1:0] ovw_d, stale_d;

  always_comb begin
    ovw_en   = ovw_inc;
    stale_en = (stale_inc != '0);
    ovw_d    = cnt_ovw + CNT_W'(1);
    stale_d  = cnt_stale + CNT_W'(stale_inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_ovw   <= '0;
      cnt_stale <= '0;
    end else begin
      if (ovw_en)   cnt_ovw   <= ovw_d;
      if (stale_en) cnt_stale <= stale_d;
    end
  end
endmodule

// File: rtl/prefetch_issue_queue.sv
module prefetch_issue_queue
  import piq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int ADDR_W   = 32,
  parameter int BLK_BITS = 5,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              bus_busy,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              issue_valid,
  output logic [ADDR_W-1:0] issue_addr,
  output logic [CNT_W-1:0]  cnt_overwrite,
  output logic [CNT_W-1:0]  cnt_stale
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int BLK_W = ADDR_W - BLK_BITS;

  // Ring state
  logic [DEPTH-1:0][BLK_W-1:0] blk_q;
  logic [DEPTH-1:0]            vld_q, vld_d;
  logic [PTR_W-1:0]            head_q, head_d;
  logic [OCC_W-1:0]            occ_q, occ_d;

  logic [BLK_W-1:0] push_blk, snoop_blk;
  logic [DEPTH-1:0] snp_hit, dup_hit, live;
  logic [OCC_W-1:0] off, eff_occ, after_iss, stale_n;
  logic [PTR_W-1:0] eff_head, tail;
  logic             dup, iss, wr_en;
  push_kind_e       kind;
  logic             unused_lo;

  function automatic logic [PTR_W-1:0] ring(input int unsigned a);
    ring = PTR_W'(a % DEPTH);
  endfunction

  assign push_blk  = push_addr[ADDR_W-1:BLK_BITS];
  assign snoop_blk = snoop_addr[ADDR_W-1:BLK_BITS];
  assign unused_lo = ^{push_addr[BLK_BITS-1:0], snoop_addr[BLK_BITS-1:0]};

  // Demand snoop cancels matching requests
  piq_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_snoop (
    .blk(blk_q), .vld(vld_q), .en(snoop_valid), .key(snoop_blk), .hit(snp_hit)
  );
  assign live = vld_q & ~snp_hit;

  // Duplicate filter against surviving requests
  piq_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_dup (
    .blk(blk_q), .vld(live), .en(push_valid), .key(push_blk), .hit(dup_hit)
  );

  // Skip dead slots at the old end
  piq_pick #(.DEPTH(DEPTH)) u_pick (
    .live(live), .head(head_q), .occ(occ_q), .off(off)
  );

  always_comb begin
    eff_occ   = occ_q - off;
    eff_head  = ring(int'(head_q) + int'(off));
    tail      = ring(int'(head_q) + int'(occ_q));
    iss       = (eff_occ != '0) && !bus_busy;
    after_iss = eff_occ - OCC_W'(iss);
    dup       = (|dup_hit) || (snoop_valid && (snoop_blk == push_blk));
    stale_n   = '0;
    for (int i = 0; i < DEPTH; i++) stale_n = stale_n + OCC_W'(snp_hit[i]);

    if (!push_valid)                    kind = PUSH_NONE;
    else if (dup)                       kind = PUSH_DROP;
    else if (after_iss == OCC_W'(DEPTH)) kind = PUSH_EVICT;
    else                                kind = PUSH_APPEND;
    wr_en = (kind == PUSH_APPEND) || (kind == PUSH_EVICT);

    // Next state
    vld_d  = live;
    head_d = ring(int'(eff_head) + int'(iss) + int'(kind == PUSH_EVICT));
    occ_d  = after_iss + OCC_W'(kind == PUSH_APPEND);
    if (iss || kind == PUSH_EVICT) vld_d[eff_head] = 1'b0;
    if (wr_en)                     vld_d[tail]     = 1'b1;
  end

  assign issue_valid = iss;
  assign issue_addr  = {blk_q[eff_head], {BLK_BITS{1'b0}}};

  piq_tally #(.CNT_W(CNT_W), .INC_W(OCC_W)) u_tally (
    .clk(clk), .rst_n(rst_n),
    .ovw_inc(kind == PUSH_EVICT), .stale_inc(stale_n),
    .cnt_ovw(cnt_overwrite), .cnt_stale(cnt_stale)
  );

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      occ_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      head_q <= head_d;
      occ_q  <= occ_d;
    end
  end

  // Payload registers, write-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_en) blk_q[tail] <= push_blk;
  end
endmodule

// File: rtl/piq_checker.sv
module piq_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             bus_busy,
  input logic             snoop_valid,
  input logic             issue_valid,
  input logic [CNT_W-1:0] cnt_overwrite,
  input logic [CNT_W-1:0] cnt_stale,
  input logic [OCC_W-1:0] occ
);
  AST_NO_ISSUE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !issue_valid); // R2
  AST_EMPTY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !issue_valid); // R3
  AST_OVW_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid |=> $stable(cnt_overwrite)); // R4
  AST_OVW_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_overwrite) |-> cnt_overwrite == $past(cnt_overwrite) + CNT_W'(1)); // R4
  AST_NO_OVW_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> $stable(cnt_overwrite)); // R5
  AST_STALE_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_valid |=> $stable(cnt_stale)); // R7
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH)); // R10
endmodule

bind prefetch_issue_queue piq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_piq_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .bus_busy(bus_busy),
  .snoop_valid(snoop_valid), .issue_valid(issue_valid),
  .cnt_overwrite(cnt_overwrite), .cnt_stale(cnt_stale), .occ(occ_q)
);

// File: tb/prefetch_issue_queue_test.sv
module prefetch_issue_queue_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int BB    = 4;
  localparam int CW    = 8;

  logic clk, rst_n, push_valid, bus_busy, snoop_valid, issue_valid;
  logic [AW-1:0] push_addr, snoop_addr, issue_addr;
  logic [CW-1:0] cnt_overwrite, cnt_stale;

  int total, bad, exp_ovw, exp_stale;
  bit done;
  // Scoreboard ring: block address and liveness per slot, oldest first
  logic [AW-BB-1:0] sb_blk[$];
  bit               sb_live[$];

  prefetch_issue_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .BLK_BITS(BB), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_addr(push_addr),
    .bus_busy(bus_busy), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .issue_valid(issue_valid), .issue_addr(issue_addr),
    .cnt_overwrite(cnt_overwrite), .cnt_stale(cnt_stale)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle and compare the design against the scoreboard
  task automatic step(input bit p, input logic [AW-1:0] pa, input bit busy,
                      input bit s, input logic [AW-1:0] sa, input string tag);
    bit dup, exp_iv;
    @(negedge clk);
    chk(cnt_overwrite == CW'(exp_ovw), {tag, "/R4 ovw count"}, int'(cnt_overwrite), exp_ovw);
    chk(cnt_stale == CW'(exp_stale), {tag, "/R7 stale count"}, int'(cnt_stale), exp_stale);
    push_valid = p; push_addr = pa; bus_busy = busy; snoop_valid = s; snoop_addr = sa;
    #1;
    if (s) foreach (sb_blk[i]) if (sb_live[i] && sb_blk[i] == sa[AW-1:BB]) begin
      sb_live[i] = 1'b0; exp_stale++;
    end
    dup = s && (sa[AW-1:BB] == pa[AW-1:BB]);
    foreach (sb_blk[i]) if (sb_live[i] && sb_blk[i] == pa[AW-1:BB]) dup = 1'b1;
    while (sb_blk.size() > 0 && !sb_live[0]) begin
      void'(sb_blk.pop_front()); void'(sb_live.pop_front());
    end
    exp_iv = !busy && sb_blk.size() > 0;
    chk(issue_valid == exp_iv, {tag, " issue_valid"}, int'(issue_valid), int'(exp_iv));
    if (exp_iv) begin
      chk(issue_addr == {sb_blk[0], {BB{1'b0}}}, {tag, " issue_addr"},
          int'(issue_addr), int'({sb_blk[0], {BB{1'b0}}}));
      void'(sb_blk.pop_front()); void'(sb_live.pop_front());
    end
    if (p && !dup) begin
      if (sb_blk.size() == DEPTH) begin
        void'(sb_blk.pop_front()); void'(sb_live.pop_front()); exp_ovw++;
      end
      sb_blk.push_back(pa[AW-1:BB]); sb_live.push_back(1'b1);
    end
  endtask

  task automatic idle(input bit busy, input string tag);
    step(1'b0, '0, busy, 1'b0, '0, tag);
  endtask

  task automatic put(input logic [AW-1:0] a, input bit busy, input string tag);
    step(1'b1, a, busy, 1'b0, '0, tag);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; exp_ovw = 0; exp_stale = 0; done = 0;
    rst_n = 1'b0; push_valid = 0; push_addr = '0; bus_busy = 0;
    snoop_valid = 0; snoop_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    idle(1'b0, "R1");
    // R2/R3: hold while busy, then oldest-first
    put(16'h0100, 1, "R2"); put(16'h0210, 1, "R2"); put(16'h0320, 1, "R2");
    idle(1'b1, "R2");
    idle(1'b0, "R3"); idle(1'b0, "R3"); idle(1'b0, "R3"); idle(1'b0, "R3");
    // R10/R4: fill, then evict oldest
    put(16'h1000, 1, "R10"); put(16'h1100, 1, "R10");
    put(16'h1200, 1, "R10"); put(16'h1300, 1, "R10");
    put(16'h1400, 1, "R4");
    repeat (5) idle(1'b0, "R4");
    // R5: full ring, push with issue
    put(16'h2000, 1, "R5"); put(16'h2100, 1, "R5");
    put(16'h2200, 1, "R5"); put(16'h2300, 1, "R5");
    put(16'h2400, 0, "R5");
    repeat (5) idle(1'b0, "R5");
    // R6: same block pushed twice
    put(16'h3000, 1, "R6"); put(16'h3007, 1, "R6"); put(16'h3100, 1, "R6");
    repeat (3) idle(1'b0, "R6");
    // R7/R8: cancel oldest, then cancel next while bus frees
    put(16'h4000, 1, "R7"); put(16'h4100, 1, "R7"); put(16'h4200, 1, "R7");
    step(1'b0, '0, 1'b1, 1'b1, 16'h400c, "R7");
    step(1'b0, '0, 1'b0, 1'b1, 16'h4100, "R8");
    idle(1'b0, "R8");
    // R9: push collides with same-cycle snoop
    step(1'b1, 16'h5000, 1'b0, 1'b1, 16'h5003, "R9");
    idle(1'b0, "R9");
    // R8: hole in the middle
    put(16'h6000, 1, "R8"); put(16'h6100, 1, "R8"); put(16'h6200, 1, "R8");
    step(1'b0, '0, 1'b1, 1'b1, 16'h6100, "R8");
    idle(1'b0, "R8"); idle(1'b0, "R8"); idle(1'b0, "R8");
    // R10: hole keeps its slot; fill around it forces an eviction
    put(16'h7000, 1, "R10"); put(16'h7100, 1, "R10"); put(16'h7200, 1, "R10");
    step(1'b0, '0, 1'b1, 1'b1, 16'h7100, "R10");
    put(16'h7300, 1, "R10"); put(16'h7400, 1, "R10");
    repeat (4) idle(1'b0, "R10");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule